// File: doc/BRIEF.md
# Serial-Addressed Bit Memory Front End

This block is the address and read-out front end of a bit-serial read-only memory meant for voice playback. The host first shifts a 24-bit start address in, most significant bit first, one bit on each rising edge of an address clock pin. The top bits of that address are a page code. When the 24th bit arrives, the block compares the page code with the page number fixed for this device. It unmasks its data output only if they match. On a device with no page code, every load enables it.

Once the block is enabled, each falling edge of a separate read clock pin steps an offset counter, and the stored bit at the new position appears on the data output. A bank-select pin supplies one more address bit above the offset. A cascade-enable pin decides whether the incoming address bits are repeated on a second data pin for devices further down the chain.

All pins are resynchronised into one system clock domain, and every pin edge is acted on from that clock.

Top module: `serial_voice_rom`

## Requirements
- R1: The start address is taken from 24 consecutive address-clock rising edges, most significant bit first. After a matching load, `data_o` shows the stored bit at the loaded offset.
- R2: A load sequence begins on the first address-clock rising edge after reset, or on the first one after a completed 24-bit load. That edge clears the shift register. From then until the 24th bit, `data_oe_o` is 0.
- R3: After 24 bits, `data_oe_o` becomes 1 only if address bits [23:24-PAGE_W] equal PAGE_ID (defaults 3 and 5, that is 3'b101). On a mismatch, `data_oe_o` and `data_o` stay 0 until the next complete load.
- R4: While enabled, each read-clock falling edge adds one to the offset, and `data_o` shows the bit at the new offset.
- R5: Read-clock edges are ignored during an address load and while the device is disabled. The offset seen after the load is the loaded one.
- R6: The offset counter wraps from all ones to zero inside its 24-PAGE_W bit field, and the device stays enabled.
- R7: When `chain_en_i` is 1, `chain_o` repeats each address bit after its address-clock rising edge. When `chain_en_i` is 0, `chain_o` is 0.
- R8: `bank_sel_i` is the top bit of the storage index: index = {bank, offset[MEM_AW-2:0]}.
- R9: The stored bit at index i is the XOR-reduction of (i AND ROM_MASK), with default ROM_MASK 10'h2D3.
- R10: After reset, `data_o`, `data_oe_o` and `chain_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all pins |
| rst | input | 1 | Synchronous active-high reset |
| addr_clk_i | input | 1 | Address shift clock; rising edge takes one bit |
| rd_clk_i | input | 1 | Read clock; falling edge steps the offset |
| sdio_i | input | 1 | Serial address bit input |
| chain_en_i | input | 1 | 1: repeat address bits to downstream devices |
| bank_sel_i | input | 1 | Upper/lower half select, top storage index bit |
| data_o | output | 1 | Stored bit at the current position (0 when masked) |
| data_oe_o | output | 1 | Output enable of the data pin; 0 means high impedance |
| chain_o | output | 1 | Cascade copy of the address bit stream |

## Verification
The assertions watch these on every cycle:
- The load counter never passes 24.
- The completion pulse lasts one cycle.
- The offset does not move while a load is in progress.
- Each accepted read edge adds exactly one, and all ones wraps to zero with the device still enabled.
- The output enable only rises as a delayed copy of an enable granted at the end of a load.

Only the bench scenarios can show the rest:
- Bit order and the bit values read from storage.
- Page-code decisions for specific addresses.
- Read clocks toggled in the middle of a load being dropped.
- The cascade bit stream.
- The effect of flipping the bank pin without reloading.

// File: rtl/svr_pkg.sv
package svr_pkg;
  localparam int unsigned ADDR_W = 24;
  localparam int unsigned CNT_W  = $clog2(ADDR_W + 1);
  typedef logic [ADDR_W-1:0] addr_t;
endpackage

// File: rtl/svr_pin_sync.sv
module svr_pin_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] pipe_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < STAGES; k++) pipe_q[k] <= '0;
    end else begin
      pipe_q[0] <= d_i;
      for (int k = 1; k < STAGES; k++) pipe_q[k] <= pipe_q[k-1];
    end
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/svr_addr_shift.sv
module svr_addr_shift
  import svr_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  a_rise_i,
  input  logic  bit_i,
  input  logic  chain_sel_i,
  output addr_t addr_o,
  output logic  busy_o,
  output logic  done_o,
  output logic  chain_o
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(ADDR_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(ADDR_W - 1);

  logic [CNT_W-1:0] cnt_q;
  addr_t            sh_q;
  logic             done_q;
  logic             chain_q;
  logic             fresh;

  // a new sequence starts from idle or right after a full word
  assign fresh = (cnt_q == '0) || (cnt_q == FULL);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      sh_q   <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (a_rise_i) begin
        if (fresh) begin
          sh_q  <= addr_t'(bit_i);
          cnt_q <= CNT_W'(1);
        end else begin
          sh_q   <= {sh_q[ADDR_W-2:0], bit_i};
          cnt_q  <= cnt_q + CNT_W'(1);
          done_q <= (cnt_q == LAST);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !chain_sel_i) chain_q <= 1'b0;
    else if (a_rise_i)       chain_q <= bit_i;
  end

  assign addr_o  = sh_q;
  assign busy_o  = !fresh;
  assign done_o  = done_q;
  assign chain_o = chain_q;

  p_cnt_range_r2: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= FULL);
  p_done_pulse_r1: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);
  p_done_at_full_r1: assert property (@(posedge clk) disable iff (rst)
    done_q |-> cnt_q == FULL);
  p_chain_off_r7: assert property (@(posedge clk) disable iff (rst)
    !chain_sel_i |=> !chain_q);
endmodule

// File: rtl/svr_read_ctr.sv
module svr_read_ctr
  import svr_pkg::*;
#(
  parameter int unsigned PAGE_W  = 3,
  parameter int unsigned PAGE_ID = 5,
  localparam int unsigned OFS_W  = ADDR_W - PAGE_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  addr_t            start_i,
  input  logic             busy_i,
  input  logic             r_fall_i,
  output logic [OFS_W-1:0] ofs_o,
  output logic             en_o
);
  logic             match;
  logic [OFS_W-1:0] ofs_q;
  logic             en_q;

  generate
    if (PAGE_W == 0) begin : g_nopage
      assign match = 1'b1;
    end else begin : g_page
      assign match = (start_i[ADDR_W-1 -: PAGE_W] == PAGE_W'(PAGE_ID));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      ofs_q <= '0;
      en_q  <= 1'b0;
    end else if (load_i) begin
      ofs_q <= start_i[OFS_W-1:0];
      en_q  <= match;
    end else if (busy_i) begin
      en_q  <= 1'b0;
    end else if (r_fall_i && en_q) begin
      ofs_q <= ofs_q + OFS_W'(1);
    end
  end

  assign ofs_o = ofs_q;
  assign en_o  = en_q;

  p_enable_on_load_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(en_q) |-> $past(load_i));
  p_hold_while_loading_r5: assert property (@(posedge clk) disable iff (rst)
    (busy_i && !load_i) |=> $stable(ofs_q));
  p_step_r4: assert property (@(posedge clk) disable iff (rst)
    (en_q && r_fall_i && !busy_i && !load_i) |=> ofs_q == OFS_W'($past(ofs_q) + OFS_W'(1)));
  p_wrap_r6: assert property (@(posedge clk) disable iff (rst)
    (en_q && r_fall_i && !busy_i && !load_i && ofs_q == '1) |=> (ofs_q == '0 && en_q));
endmodule

// File: rtl/svr_bit_rom.sv
module svr_bit_rom #(
  parameter int unsigned AW   = 10,
  parameter int unsigned MASK = 'h2D3,
  localparam int unsigned DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic [AW-1:0] addr_i,
  output logic          bit_o
);
  logic mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = ^(i[AW-1:0] & MASK[AW-1:0]);
  end

  always_ff @(posedge clk) bit_o <= mem[addr_i];
endmodule

// File: rtl/serial_voice_rom.sv
module serial_voice_rom
  import svr_pkg::*;
#(
  parameter int unsigned PAGE_W      = 3,
  parameter int unsigned PAGE_ID     = 5,
  parameter int unsigned MEM_AW      = 10,
  parameter int unsigned ROM_MASK    = 'h2D3,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic addr_clk_i,
  input  logic rd_clk_i,
  input  logic sdio_i,
  input  logic chain_en_i,
  input  logic bank_sel_i,
  output logic data_o,
  output logic data_oe_o,
  output logic chain_o
);
  localparam int unsigned OFS_W = ADDR_W - PAGE_W;

  logic [4:0]       pins_s;
  logic             addr_s, rd_s, sdio_s, chain_s, bank_s;
  logic [1:0]       clk_d;
  logic             a_rise, r_fall;
  addr_t            start_addr;
  logic             busy, done;
  logic [OFS_W-1:0] ofs;
  logic             en, en_d;
  logic             rom_bit;

  svr_pin_sync #(.W(5), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i ({bank_sel_i, chain_en_i, sdio_i, rd_clk_i, addr_clk_i}),
    .q_o (pins_s)
  );
  assign {bank_s, chain_s, sdio_s, rd_s, addr_s} = pins_s;

  always_ff @(posedge clk) begin
    if (rst) clk_d <= '0;
    else     clk_d <= {rd_s, addr_s};
  end
  assign a_rise = addr_s & ~clk_d[0];
  assign r_fall = ~rd_s & clk_d[1];

  svr_addr_shift u_shift (
    .clk         (clk),
    .rst         (rst),
    .a_rise_i    (a_rise),
    .bit_i       (sdio_s),
    .chain_sel_i (chain_s),
    .addr_o      (start_addr),
    .busy_o      (busy),
    .done_o      (done),
    .chain_o     (chain_o)
  );

  svr_read_ctr #(.PAGE_W(PAGE_W), .PAGE_ID(PAGE_ID)) u_ctr (
    .clk      (clk),
    .rst      (rst),
    .load_i   (done),
    .start_i  (start_addr),
    .busy_i   (busy),
    .r_fall_i (r_fall),
    .ofs_o    (ofs),
    .en_o     (en)
  );

  svr_bit_rom #(.AW(MEM_AW), .MASK(ROM_MASK)) u_rom (
    .clk    (clk),
    .addr_i ({bank_s, ofs[MEM_AW-2:0]}),
    .bit_o  (rom_bit)
  );

  // enable is delayed one stage to line up with the registered storage read
  always_ff @(posedge clk) begin
    if (rst) begin
      en_d      <= 1'b0;
      data_o    <= 1'b0;
      data_oe_o <= 1'b0;
    end else begin
      en_d      <= en;
      data_oe_o <= en_d;
      data_o    <= en_d & rom_bit;
    end
  end

  p_oe_tracks_enable_r3: assert property (@(posedge clk) disable iff (rst)
    data_oe_o |-> $past(en, 2));
  p_load_clears_oe_r2: assert property (@(posedge clk) disable iff (rst)
    (busy && !done) |=> ##2 !data_oe_o);
endmodule

// File: tb/serial_voice_rom_bench.sv
module serial_voice_rom_bench;
  localparam int PERIOD = 10;
  localparam int HOLD   = 4;
  localparam int SETTLE = 10;
  localparam int VEC_N  = 6;

  // {bank, start address, read count, expected enable}
  localparam logic [29:0] VEC [VEC_N] = '{
    {1'b0, 24'hA00000, 4'd5, 1'b1},
    {1'b1, 24'hA0012C, 4'd6, 1'b1},
    {1'b0, 24'hB5A5A5, 4'd7, 1'b1},
    {1'b0, 24'h400000, 4'd3, 1'b0},
    {1'b1, 24'hFFFFFF, 4'd2, 1'b0},
    {1'b1, 24'hBFFFFE, 4'd4, 1'b1}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic addr_clk = 1'b0, rd_clk = 1'b0, sdio = 1'b0, chain_en = 1'b0, bank = 1'b0;
  logic data, data_oe, chain;
  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  serial_voice_rom u_serial_voice_rom (
    .clk        (clk),
    .rst        (rst),
    .addr_clk_i (addr_clk),
    .rd_clk_i   (rd_clk),
    .sdio_i     (sdio),
    .chain_en_i (chain_en),
    .bank_sel_i (bank),
    .data_o     (data),
    .data_oe_o  (data_oe),
    .chain_o    (chain)
  );

  function automatic logic ebit(logic b, logic [20:0] ofs);
    logic [9:0] idx;
    idx = {b, ofs[8:0]};
    return ^(idx & 10'h2D3);
  endfunction

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string tag, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic addr_bit(logic b);
    sdio = b;
    tick(HOLD);
    addr_clk = 1'b1;
    tick(HOLD);
    addr_clk = 1'b0;
    tick(HOLD);
  endtask

  task automatic load_range(logic [23:0] a, int hi, int lo);
    for (int i = hi; i >= lo; i--) addr_bit(a[i]);
  endtask

  task automatic rd_pulse();
    rd_clk = 1'b1;
    tick(HOLD);
    rd_clk = 1'b0;
    tick(SETTLE);
  endtask

  initial begin
    tick(5);
    rst = 1'b0;
    tick(3);
    // R10 reset state
    chk("R10 data", data, 0);
    chk("R10 oe", data_oe, 0);
    chk("R10 chain", chain, 0);

    // table-driven loads and reads (R1 R3 R4 R6 R9)
    for (int v = 0; v < VEC_N; v++) begin
      logic [23:0] a;
      logic [20:0] ofs;
      logic        en;
      bank = VEC[v][29];
      a    = VEC[v][28:5];
      en   = VEC[v][0];
      ofs  = a[20:0];
      load_range(a, 23, 0);
      tick(SETTLE);
      chk("R3 enable", data_oe, en);
      chk("R1 first bit", data, en ? ebit(bank, ofs) : 0);
      for (int r = 0; r < int'(VEC[v][4:1]); r++) begin
        rd_pulse();
        if (en) ofs = ofs + 21'd1;
        chk("R4 step bit", data, en ? ebit(bank, ofs) : 0);
        chk("R6 stays enabled", data_oe, en);
      end
    end

    // R2: an extra edge after a complete load opens a new sequence
    bank = 1'b0;
    load_range(24'hA00010, 23, 0);
    tick(SETTLE);
    chk("R2 before", data_oe, 1);
    load_range(24'hA00200, 23, 23);
    tick(SETTLE);
    chk("R2 masked during load", data_oe, 0);
    load_range(24'hA00200, 22, 0);
    tick(SETTLE);
    chk("R2 new load enabled", data_oe, 1);
    chk("R2 new load bit", data, ebit(1'b0, 21'h000200));

    // R5: read clocks in the middle of a load are dropped
    load_range(24'hA00011, 23, 14);
    rd_pulse();
    rd_pulse();
    rd_pulse();
    load_range(24'hA00011, 13, 0);
    tick(SETTLE);
    chk("R5 offset kept", data, ebit(1'b0, 21'h000011));
    rd_pulse();
    chk("R5 step after", data, ebit(1'b0, 21'h000012));

    // R7: cascade repeats each bit
    chain_en = 1'b1;
    tick(SETTLE);
    begin
      logic [23:0] ca;
      ca = 24'hA5C3F0;
      for (int i = 23; i >= 0; i--) begin
        addr_bit(ca[i]);
        chk("R7 chain bit", chain, ca[i]);
      end
    end
    chain_en = 1'b0;
    tick(SETTLE);
    chk("R7 chain off", chain, 0);

    // R8: bank pin is the top index bit
    bank = 1'b0;
    load_range(24'hA00001, 23, 0);
    tick(SETTLE);
    chk("R8 bank 0", data, ebit(1'b0, 21'h000001));
    bank = 1'b1;
    tick(SETTLE);
    chk("R8 bank 1", data, ebit(1'b1, 21'h000001));

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog R1 actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule